// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block watches one infrared receiver line and turns it into a stream of run-length symbols. Each symbol is a byte: it gives the level of a run and how many sample periods that run lasted. The line is sampled once every `DIV` clock cycles, which is 64 by default, and only while both enables are high. An optional inversion adapts the block to receivers whose output idles high and is pulled low by light.

Level changes that do not last for the noise threshold are treated as glitches and become part of the run around them. A packet begins with the first active sample. When the line stays inactive for a programmable multiple of 128 samples, the packet closes with a single strobe, and the space that closed it produces no symbol. Runs longer than 128 samples are split into full-length symbols followed by the remainder. Symbols are offered for one cycle. If the consumer is not ready in that cycle, the symbol is lost and a drop flag is raised so that a downstream store can record an overflow.

Top module: `ir_rl_sampler`

## Requirements
- R1: The line is sampled once every 64 clock cycles. A level held for N×64 cycles counts as exactly N samples.
- R2: A symbol byte carries the run level in bit 7 (1 = active, 0 = space) and the run length in samples minus one in bits 6:0.
- R3: With `invert_i` high, a low raw input is the active level. With `invert_i` low, a high raw input is the active level.
- R4: The filtered level changes only after the new level has been seen for `noise_thr_i` consecutive samples (a value of 0 acts as 1). Shorter excursions are absorbed into the surrounding run, and accepted runs keep their true length.
- R5: After (`idle_thr_i`+1)×128 consecutive space samples within a packet, `pkt_end_o` pulses for one cycle. The packet then closes, the closing space emits no symbol, and no further strobe follows while the line stays idle.
- R6: No symbol is emitted while idle before the first active sample. After a packet ends, the block waits for an active level before it starts a new packet.
- R7: Each time a run reaches 128 samples and continues, a symbol of that level with length field 127 is emitted, and the run keeps counting. This also applies to a space that has not yet reached the idle limit.
- R8: Unless both `glb_en_i` and `rx_en_i` are high, no symbol and no packet-end strobe is produced, and run and filter state return to idle.
- R9: `sym_valid_o` is a one-cycle pulse. If `sym_ready_i` is low in that cycle, the symbol is lost and `drop_o` pulses in the next cycle.
- R10: During and directly after reset, `sym_valid_o`, `pkt_end_o` and `drop_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global enable |
| rx_en_i | input | 1 | Receive enable |
| ir_raw_i | input | 1 | Raw receiver line, asynchronous |
| invert_i | input | 1 | Invert line polarity before sampling |
| noise_thr_i | input | 6 | Minimum accepted run length in samples |
| idle_thr_i | input | 8 | Idle limit, in units of 128 samples, minus one |
| sym_valid_o | output | 1 | Symbol valid pulse |
| sym_data_o | output | 8 | Symbol: level in bit 7, length minus one in bits 6:0 |
| sym_ready_i | input | 1 | Consumer ready |
| pkt_end_o | output | 1 | Packet-end strobe |
| drop_o | output | 1 | Symbol lost because the consumer was not ready |

## Verification
The bench goes after runs that cross the 128-sample chunk boundary, and after a space one sample short of the idle limit next to a space that reaches it exactly. A design with an off-by-one in either counter would shift a length field by one, emit a spurious chunk, or fire packet end early. Glitches shorter than the noise threshold are placed both inside a pulse and on an idle line. A filter that counted wrongly would split the pulse, or would open a packet on a glitch. Inverted polarity, disabled operation and a consumer that is never ready are also exercised: a wrong design would emit inverted symbols, produce output while disabled, or fail to flag lost symbols.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
  localparam int LEN_W = 7;
  localparam int SYM_W = LEN_W + 1;
  localparam int CHUNK = 1 << LEN_W;

  typedef struct packed {
    logic             lvl;
    logic [LEN_W-1:0] len_m1;
  } ir_sym_t;
endpackage

// File: rtl/ir_rl_presc.sv
module ir_rl_presc #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(DIV - 1));
  assign tick_o = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (last)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ir_rl_filter.sv
module ir_rl_filter #(
  parameter int SYNC   = 2,
  parameter int NTHR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              raw_i,
  input  logic              inv_i,
  input  logic [NTHR_W-1:0] thr_i,
  output logic              lvl_o,
  output logic              lvl_vld_o
);
  logic [SYNC-1:0] sync_q;
  logic            smp;
  logic            filt_q;
  logic            vld_q;
  logic [NTHR_W:0] cnt_q;
  logic [NTHR_W:0] thr_eff;
  logic [NTHR_W:0] cnt_inc;

  generate
    if (SYNC > 1) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC-2:0], raw_i};
      end
    end else begin : g_nosync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= raw_i;
      end
    end
  endgenerate

  assign smp     = sync_q[SYNC-1] ^ inv_i;
  assign thr_eff = (thr_i == '0) ? (NTHR_W+1)'(1) : {1'b0, thr_i};
  assign cnt_inc = cnt_q + 1'b1;

  // debounce: new level must persist thr_eff samples before it is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else if (!en_i) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= tick_i;
      if (tick_i) begin
        if (smp == filt_q) begin
          cnt_q <= '0;
        end else if (cnt_inc >= thr_eff) begin
          filt_q <= smp;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  assign lvl_o     = filt_q;
  assign lvl_vld_o = vld_q;
endmodule

// File: rtl/ir_rl_engine.sv
module ir_rl_engine
  import ir_rl_pkg::*;
#(
  parameter int ITHR_W    = 8,
  parameter int IDLE_UNIT = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic              lvl_i,
  input  logic [ITHR_W-1:0] ithr_i,
  output logic              sym_vld_o,
  output ir_sym_t           sym_o,
  output logic              pkt_end_o
);
  localparam int UNIT_SH = $clog2(IDLE_UNIT);
  localparam int IDLE_W  = ITHR_W + 1 + UNIT_SH;
  localparam int CNT_W   = LEN_W + 1;

  logic              in_q, n_in;
  logic              cur_q, n_cur;
  logic [CNT_W-1:0]  cnt_q, n_cnt;
  logic [IDLE_W-1:0] spc_q, n_spc, spc_inc, limit;
  logic              e_vld, e_end;
  ir_sym_t           e_sym;
  logic              vld_q, end_q;
  ir_sym_t           sym_q;

  assign limit   = (IDLE_W'(ithr_i) + IDLE_W'(1)) << UNIT_SH;
  assign spc_inc = spc_q + 1'b1;

  always_comb begin
    n_in   = in_q;
    n_cur  = cur_q;
    n_cnt  = cnt_q;
    n_spc  = spc_q;
    e_vld  = 1'b0;
    e_end  = 1'b0;
    e_sym  = '0;
    if (vld_i) begin
      if (!in_q) begin
        if (lvl_i) begin
          n_in  = 1'b1;
          n_cur = 1'b1;
          n_cnt = CNT_W'(1);
          n_spc = '0;
        end
      end else if (lvl_i != cur_q) begin
        e_vld        = 1'b1;
        e_sym.lvl    = cur_q;
        e_sym.len_m1 = LEN_W'(cnt_q - 1'b1);
        n_cur        = lvl_i;
        n_cnt        = CNT_W'(1);
        n_spc        = lvl_i ? '0 : IDLE_W'(1);
      end else if (!lvl_i && spc_inc == limit) begin
        // closing space: strobe only, no symbol
        e_end = 1'b1;
        n_in  = 1'b0;
        n_cnt = '0;
        n_spc = '0;
      end else begin
        if (!lvl_i) n_spc = spc_inc;
        if (cnt_q == CNT_W'(CHUNK)) begin
          e_vld        = 1'b1;
          e_sym.lvl    = cur_q;
          e_sym.len_m1 = LEN_W'(CHUNK - 1);
          n_cnt        = CNT_W'(1);
        end else begin
          n_cnt = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      cur_q <= 1'b0;
      cnt_q <= '0;
      spc_q <= '0;
      vld_q <= 1'b0;
      end_q <= 1'b0;
      sym_q <= '0;
    end else if (!en_i) begin
      in_q  <= 1'b0;
      cur_q <= 1'b0;
      cnt_q <= '0;
      spc_q <= '0;
      vld_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      in_q  <= n_in;
      cur_q <= n_cur;
      cnt_q <= n_cnt;
      spc_q <= n_spc;
      vld_q <= e_vld;
      end_q <= e_end;
      if (e_vld) sym_q <= e_sym;
    end
  end

  assign sym_vld_o = vld_q;
  assign sym_o     = sym_q;
  assign pkt_end_o = end_q;
endmodule

// File: rtl/ir_rl_sampler.sv
module ir_rl_sampler
  import ir_rl_pkg::*;
#(
  parameter int DIV       = 64,
  parameter int SYNC      = 2,
  parameter int NTHR_W    = 6,
  parameter int ITHR_W    = 8,
  parameter int IDLE_UNIT = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic              rx_en_i,
  input  logic              ir_raw_i,
  input  logic              invert_i,
  input  logic [NTHR_W-1:0] noise_thr_i,
  input  logic [ITHR_W-1:0] idle_thr_i,
  output logic              sym_valid_o,
  output logic [SYM_W-1:0]  sym_data_o,
  input  logic              sym_ready_i,
  output logic              pkt_end_o,
  output logic              drop_o
);
  logic    en, tick, lvl, lvl_vld, sym_vld, drop_q;
  ir_sym_t sym;

  assign en = glb_en_i & rx_en_i;

  ir_rl_presc #(.DIV(DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .tick_o(tick)
  );

  ir_rl_filter #(.SYNC(SYNC), .NTHR_W(NTHR_W)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .tick_i   (tick),
    .raw_i    (ir_raw_i),
    .inv_i    (invert_i),
    .thr_i    (noise_thr_i),
    .lvl_o    (lvl),
    .lvl_vld_o(lvl_vld)
  );

  ir_rl_engine #(.ITHR_W(ITHR_W), .IDLE_UNIT(IDLE_UNIT)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .vld_i    (lvl_vld),
    .lvl_i    (lvl),
    .ithr_i   (idle_thr_i),
    .sym_vld_o(sym_vld),
    .sym_o    (sym),
    .pkt_end_o(pkt_end_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= sym_vld & ~sym_ready_i;
  end

  assign sym_valid_o = sym_vld;
  assign sym_data_o  = sym;
  assign drop_o      = drop_q;
endmodule

// File: rtl/ir_rl_sampler_chk.sv
module ir_rl_sampler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic glb_en_i,
  input logic rx_en_i,
  input logic sym_valid_o,
  input logic sym_ready_i,
  input logic pkt_end_o,
  input logic drop_o
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |=> !sym_valid_o);

  // R5
  end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |=> !pkt_end_o);

  // R5
  end_no_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> !sym_valid_o);

  // R9
  drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !sym_ready_i) |=> drop_o);

  // R9
  drop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $past(sym_valid_o && !sym_ready_i));

  // R8
  quiet_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(glb_en_i && rx_en_i) && $past(!(glb_en_i && rx_en_i)))
      |-> (!sym_valid_o && !pkt_end_o));
endmodule

bind ir_rl_sampler ir_rl_sampler_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .glb_en_i   (glb_en_i),
  .rx_en_i    (rx_en_i),
  .sym_valid_o(sym_valid_o),
  .sym_ready_i(sym_ready_i),
  .pkt_end_o  (pkt_end_o),
  .drop_o     (drop_o)
);

// File: tb/ir_rl_sampler_test.sv
module ir_rl_sampler_test;
  localparam int DIV = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       glb_en_i = 1'b0, rx_en_i = 1'b0;
  logic       ir_raw_i = 1'b0, invert_i = 1'b0;
  logic [5:0] noise_thr_i = 6'd1;
  logic [7:0] idle_thr_i = 8'd0;
  logic       sym_ready_i = 1'b1;
  logic       sym_valid_o, pkt_end_o, drop_o;
  logic [7:0] sym_data_o;

  int checks = 0, fails = 0;
  logic [7:0] got [64];
  int n_got = 0, n_end = 0, n_drop = 0;
  logic [7:0] exp_q [16];
  int n_exp = 0;
  int b_got, b_end, b_drop;

  always #2 clk_i = ~clk_i;

  ir_rl_sampler uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .rx_en_i(rx_en_i),
    .ir_raw_i(ir_raw_i), .invert_i(invert_i), .noise_thr_i(noise_thr_i),
    .idle_thr_i(idle_thr_i), .sym_valid_o(sym_valid_o), .sym_data_o(sym_data_o),
    .sym_ready_i(sym_ready_i), .pkt_end_o(pkt_end_o), .drop_o(drop_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sym_valid_o) begin
        if (n_got < 64) got[n_got] = sym_data_o;
        n_got++;
      end
      if (pkt_end_o) n_end++;
      if (drop_o) n_drop++;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // line level in active/space terms; raw follows polarity
  task automatic hold(input logic lvl, input int n);
    ir_raw_i = lvl ^ invert_i;
    repeat (n * DIV) @(negedge clk_i);
  endtask

  task automatic start_case();
    b_got = n_got; b_end = n_end; b_drop = n_drop; n_exp = 0;
  endtask

  task automatic add_exp(input logic lvl, input int len);
    exp_q[n_exp] = {lvl, 7'(len - 1)};
    n_exp++;
  endtask

  task automatic end_case(input string req, input int ends, input int drops);
    repeat (8) @(negedge clk_i);
    check_eq({req, " symbol count"}, n_got - b_got, n_exp);
    for (int i = 0; i < n_exp; i++)
      if (b_got + i < n_got && b_got + i < 64)
        check_eq({req, " symbol byte"}, int'(got[b_got + i]), int'(exp_q[i]));
    check_eq({req, " packet ends"}, n_end - b_end, ends);
    check_eq({req, " drops"}, n_drop - b_drop, drops);
  endtask

  task automatic t_reset();
    // R10
    check_eq("R10 valid", int'(sym_valid_o), 0);
    check_eq("R10 pkt_end", int'(pkt_end_o), 0);
    check_eq("R10 drop", int'(drop_o), 0);
  endtask

  task automatic t_idle_start();
    // R6: idle line before first active sample
    start_case();
    hold(0, 20);
    end_case("R6 idle", 0, 0);
  endtask

  task automatic t_basic();
    // R1 R2 R5
    start_case();
    hold(1, 10); hold(0, 5); hold(1, 3); hold(0, 140);
    add_exp(1, 10); add_exp(0, 5); add_exp(1, 3);
    end_case("R1 R2 R5 basic", 1, 0);
  endtask

  task automatic t_noise();
    // R4: glitch on idle line, then glitch inside a pulse
    noise_thr_i = 6'd4;
    start_case();
    hold(1, 3); hold(0, 10);
    end_case("R4 idle glitch", 0, 0);
    start_case();
    hold(1, 10); hold(0, 2); hold(1, 10); hold(0, 20); hold(1, 5); hold(0, 140);
    add_exp(1, 22); add_exp(0, 20); add_exp(1, 5);
    end_case("R4 pulse glitch", 1, 0);
    noise_thr_i = 6'd0;
    start_case();
    hold(1, 1); hold(0, 1); hold(1, 2); hold(0, 140);
    add_exp(1, 1); add_exp(0, 1); add_exp(1, 2);
    end_case("R4 zero threshold", 1, 0);
    noise_thr_i = 6'd1;
  endtask

  task automatic t_long();
    // R7 R5: chunking and idle limit of 256 samples
    idle_thr_i = 8'd1;
    start_case();
    hold(1, 300); hold(0, 200); hold(1, 1); hold(0, 256);
    hold(1, 2); hold(0, 255); hold(1, 2); hold(0, 260);
    add_exp(1, 128); add_exp(1, 128); add_exp(1, 44);
    add_exp(0, 128); add_exp(0, 72); add_exp(1, 1);
    add_exp(0, 128);
    add_exp(1, 2); add_exp(0, 128); add_exp(0, 127); add_exp(1, 2);
    add_exp(0, 128);
    end_case("R7 R5 long runs", 2, 0);
    idle_thr_i = 8'd0;
  endtask

  task automatic t_invert();
    // R3 R6: restart after packet end with inverted line
    rx_en_i = 1'b0;
    invert_i = 1'b1;
    ir_raw_i = 1'b1;
    repeat (10) @(negedge clk_i);
    rx_en_i = 1'b1;
    start_case();
    hold(0, 4); hold(1, 7); hold(0, 140);
    add_exp(1, 7);
    end_case("R3 R6 inverted", 1, 0);
    rx_en_i = 1'b0;
    invert_i = 1'b0;
    ir_raw_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rx_en_i = 1'b1;
  endtask

  task automatic t_enable();
    // R8
    start_case();
    rx_en_i = 1'b0;
    hold(1, 10); hold(0, 140);
    end_case("R8 rx disabled", 0, 0);
    start_case();
    rx_en_i = 1'b1; glb_en_i = 1'b0;
    hold(1, 10); hold(0, 10);
    end_case("R8 global disabled", 0, 0);
    glb_en_i = 1'b1;
    hold(0, 5);
  endtask

  task automatic t_drop();
    // R9
    sym_ready_i = 1'b0;
    start_case();
    hold(1, 5); hold(0, 3); hold(1, 2); hold(0, 140);
    add_exp(1, 5); add_exp(0, 3); add_exp(1, 2);
    end_case("R9 not ready", 1, 3);
    sym_ready_i = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    glb_en_i = 1'b1;
    rx_en_i  = 1'b1;
    t_idle_start();
    t_basic();
    t_noise();
    t_long();
    t_invert();
    t_enable();
    t_drop();
    finish_run();
  end
endmodule